// File: doc/BRIEF.md
# Dual-Rail Power-Up Sequencer with Power-Good Timer

This block holds the digital control for two switching-regulator channels: a 3.3V rail and a 5V rail. It works from four inputs. The first is an active-low shutdown input. The second is a run input that also switches the 3.3V channel. The third is an on input for the 5V channel. The fourth is a 2-bit code that picks how the channels start. From these it decides the operating mode and whether each channel is enabled. Comparators, the reference and the oscillator are outside the block. Their results arrive as synchronous flags: one flag for the timing comparator and one in-regulation flag for each channel. A single-cycle tick marks each switching cycle.

The code picks one of three start-up schemes:
- **Independent:** each on input drives its own channel.
- **5V first:** the 5V rail starts on a rising edge of the run input. The 3.3V rail follows once the timing comparator trips.
- **3.3V first:** the same ordering with the two rails swapped.

An active-low power-good output stays low until the monitored channels have been enabled and in regulation for a programmable number of switching-cycle ticks. It drops at once when a monitored channel loses regulation.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `shdn_n` is low, `mode` is 2'b00 (shutdown), both enables are low and `pg_n` is low, whatever the other inputs are. Sequencing state is discarded, so a timed start needs a new run edge afterwards.
- R2: With `shdn_n` high, `mode` is 2'b10 (run) when either enable is high and 2'b01 (standby) otherwise.
- R3: With `seq_sel` 2'b00, or the reserved 2'b11, `en3` equals `run3` and `en5` equals `on5`, each as sampled at the previous clock edge while `shdn_n` was high.
- R4: With `seq_sel` 2'b01, a run edge enables `en5` at the next clock edge. The run edge is `run3` sampled high at an edge after it was sampled low at the edge before. `en3` then rises at the edge after `tmr_trip` is sampled high, provided `en5` is already on.
- R5: With `seq_sel` 2'b10, a run edge enables `en3` at the next clock edge. `en5` then rises at the edge after `tmr_trip` is sampled high, provided `en3` is already on.
- R6: In either timed mode, sampling `run3` low turns both channels off at that clock edge.
- R7: In a timed mode, a `run3` level that is already high without a rising edge does not start either channel.
- R8: `pg_n` goes high only after the monitored condition has held across `DELAY_TICKS` sampled ticks. It then stays high while the condition holds.
- R9: In independent mode, the monitored condition is `en3` with `good3`, and `good5` and `en5` have no effect on `pg_n`.
- R10: In the timed modes, the monitored condition needs both channels enabled and both `good3` and `good5` high.
- R11: `pg_n` falls in the same cycle that a monitored regulation flag clears, with no clock edge in between.
- R12: Any break in the monitored condition restarts the delay count from zero, so a full new `DELAY_TICKS` delay is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per switching cycle |
| shdn_n | input | 1 | Shutdown control, active low |
| run3 | input | 1 | Run input; 3.3V on input in independent mode |
| on5 | input | 1 | 5V on input in independent mode |
| tmr_trip | input | 1 | Timing comparator above reference |
| seq_sel | input | 2 | Start-up scheme: 00/11 independent, 01 5V first, 10 3.3V first |
| good3 | input | 1 | 3.3V channel in regulation |
| good5 | input | 1 | 5V channel in regulation |
| mode | output | 2 | 00 shutdown, 01 standby, 10 run |
| en3 | output | 1 | 3.3V channel enable |
| en5 | output | 1 | 5V channel enable |
| pg_n | output | 1 | Power-good, high when released |

## Verification
The bench builds the block with `DELAY_TICKS` = 20 and a tick on every second clock. This brings the power-good release within 40 cycles, so each scheme can reach release and then be broken and restarted in one short run. At this delay the cycles just before and just after release can be probed directly. All three start-up schemes and the reserved code are driven through the edge and level cases, with a timing trip both before and after the first rail is on.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int unsigned DELAY_TICKS = 32000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       shdn_n,
  input  logic       run3,
  input  logic       on5,
  input  logic       tmr_trip,
  input  logic [1:0] seq_sel,
  input  logic       good3,
  input  logic       good5,
  output logic [1:0] mode,
  output logic       en3,
  output logic       en5,
  output logic       pg_n
);

  localparam int unsigned CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(DELAY_TICKS);
  localparam logic [1:0] M_SHUT = 2'b00;
  localparam logic [1:0] M_STBY = 2'b01;
  localparam logic [1:0] M_RUN  = 2'b10;

  logic          run3_q, ind3_q, ind5_q, first_q, second_q;
  logic [CW-1:0] cnt_q;
  logic          indep, five_first, timed, first_nx, second_nx, mon_ok;

  assign indep      = (seq_sel == 2'b00) || (seq_sel == 2'b11);
  assign five_first = (seq_sel == 2'b01);
  assign timed      = !indep;

  assign first_nx  = shdn_n && timed && run3 && (first_q || !run3_q);
  assign second_nx = shdn_n && timed && run3 && first_q && (second_q || tmr_trip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run3_q   <= 1'b0;
      ind3_q   <= 1'b0;
      ind5_q   <= 1'b0;
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else begin
      run3_q   <= run3;
      ind3_q   <= shdn_n && run3;
      ind5_q   <= shdn_n && on5;
      first_q  <= first_nx;
      second_q <= second_nx;
    end
  end

  assign en3 = shdn_n && (indep ? ind3_q : (five_first ? second_q : first_q));
  assign en5 = shdn_n && (indep ? ind5_q : (five_first ? first_q : second_q));

  assign mode = !shdn_n ? M_SHUT : ((en3 || en5) ? M_RUN : M_STBY);

  assign mon_ok = indep ? (en3 && good3) : (en3 && en5 && good3 && good5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!mon_ok)              cnt_q <= '0;
    else if (tick && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign pg_n = mon_ok && (cnt_q == FULL);

  AST_SHDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (cnt_q == '0 && !first_q && !second_q)); // R1
  AST_ORDERED_START: assert property (@(posedge clk) disable iff (!rst_n)
    second_q |-> first_q); // R4
  AST_RUN_LOW_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (timed && !run3) |=> (!first_q && !second_q)); // R6
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first_q) |-> ($past(run3) && !$past(run3_q))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R8
  AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pg_n |-> $past(mon_ok)); // R8
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_ok |=> (cnt_q == '0)); // R12

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
  localparam int D = 20;

  logic clk = 0, rst_n = 0, tick = 0, shdn_n = 0, run3 = 0, on5 = 0, tmr_trip = 0;
  logic [1:0] seq_sel = 2'b00;
  logic good3 = 0, good5 = 0;
  logic [1:0] mode;
  logic en3, en5, pg_n;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";

  // reference model state
  int ph = 0, mc = 0;
  bit prev_run = 0, m3 = 0, m5 = 0;

  pwr_seq_ctrl #(.DELAY_TICKS(D)) i_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shdn_n(shdn_n), .run3(run3), .on5(on5),
    .tmr_trip(tmr_trip), .seq_sel(seq_sel), .good3(good3), .good5(good5),
    .mode(mode), .en3(en3), .en5(en5), .pg_n(pg_n));

  always #2 clk = ~clk;

  function automatic bit is_ind();
    return seq_sel == 2'b00 || seq_sel == 2'b11;
  endfunction
  function automatic bit exp3();
    if (!shdn_n) return 0;
    if (is_ind()) return m3;
    return (seq_sel == 2'b01) ? (ph == 2) : (ph >= 1);
  endfunction
  function automatic bit exp5();
    if (!shdn_n) return 0;
    if (is_ind()) return m5;
    return (seq_sel == 2'b01) ? (ph >= 1) : (ph == 2);
  endfunction
  function automatic bit exp_ok();
    if (is_ind()) return exp3() && good3;
    return exp3() && exp5() && good3 && good5;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mc = 0; prev_run = 0; m3 = 0; m5 = 0;
    end else begin
      if (!exp_ok()) mc = 0;
      else if (tick && mc < D) mc = mc + 1;
      if (!shdn_n || is_ind() || !run3) ph = 0;
      else if (ph == 0 && !prev_run) ph = 1;
      else if (ph == 1 && tmr_trip) ph = 2;
      prev_run = run3;
      m3 = shdn_n && run3;
      m5 = shdn_n && on5;
    end
  end

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, expv);
    end
  endtask

  task automatic compare();
    bit e3, e5;
    logic [1:0] em;
    e3 = exp3(); e5 = exp5();
    em = !shdn_n ? 2'b00 : ((e3 || e5) ? 2'b10 : 2'b01);
    chk({tag, " en3"}, en3, e3);
    chk({tag, " en5"}, en5, e5);
    chk({tag, " mode"}, mode, em);
    chk({tag, " pg_n"}, pg_n, exp_ok() && mc == D);
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      cyc++;
      tick = cyc[0];
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset pg_n", pg_n, 0);
    rst_n = 1;
    // R1: shutdown beats everything
    tag = "R1"; run3 = 1; on5 = 1; good3 = 1; good5 = 1;
    step(3);
    chk("R1 en3 in shutdown", en3, 0);
    chk("R1 mode shutdown", mode, 0);
    // R2: standby then run
    tag = "R2"; run3 = 0; on5 = 0; shdn_n = 1;
    step(2);
    chk("R2 standby", mode, 1);
    tag = "R3"; on5 = 1;
    step(2);
    chk("R3 en5 follows on5", en5, 1);
    chk("R2 run mode", mode, 2);
    run3 = 1; on5 = 0; good5 = 0;
    step(2);
    chk("R3 en3 follows run3", en3, 1);
    chk("R3 en5 off", en5, 0);
    seq_sel = 2'b11;
    step(2);
    chk("R3 reserved code independent", en3, 1);
    // R8/R9: power-good in independent mode, 5V ignored
    tag = "R9"; seq_sel = 2'b00;
    step(50);
    chk("R9 pg high with good5 low", pg_n, 1);
    on5 = 1; step(3); on5 = 0; step(3);
    chk("R9 en5 toggle ignored", pg_n, 1);
    // R11: immediate drop
    tag = "R11"; good3 = 0; #1;
    chk("R11 immediate fall", pg_n, 0);
    step(2);
    // R12 / R8: full restart delay
    tag = "R12"; good3 = 1;
    step(30);
    chk("R12 still low before full delay", pg_n, 0);
    chk("R8 held for delay", pg_n, 0);
    step(15);
    chk("R8 released after delay", pg_n, 1);
    // R7: switch to timed while run already high
    tag = "R7"; seq_sel = 2'b01;
    step(4);
    chk("R7 no start without edge en5", en5, 0);
    chk("R7 no start without edge en3", en3, 0);
    // R4: 5V first
    tag = "R4"; run3 = 0; step(2); run3 = 1;
    step(2);
    chk("R4 en5 on after edge", en5, 1);
    chk("R4 en3 waits", en3, 0);
    tmr_trip = 1; step(2); tmr_trip = 0;
    chk("R4 en3 after trip", en3, 1);
    // R10: both monitored
    tag = "R10"; good5 = 0;
    step(50);
    chk("R10 needs good5", pg_n, 0);
    good5 = 1; step(45);
    chk("R10 release both good", pg_n, 1);
    good5 = 0; #1;
    chk("R10 5V drop pulls low", pg_n, 0);
    good5 = 1;
    // R6: run low stops both
    tag = "R6"; run3 = 0;
    step(2);
    chk("R6 en3 off", en3, 0);
    chk("R6 en5 off", en5, 0);
    // R5: 3.3V first, trip held high before edge
    tag = "R5"; seq_sel = 2'b10; tmr_trip = 1; step(1); run3 = 1;
    step(1);
    chk("R5 en3 first", en3, 1);
    chk("R5 en5 not yet", en5, 0);
    step(1);
    chk("R5 en5 after trip", en5, 1);
    tmr_trip = 0; step(45);
    chk("R8 timed release", pg_n, 1);
    // R1: shutdown mid-run, then high again without edge
    tag = "R1"; shdn_n = 0; #1;
    chk("R1 shutdown mid-run", en3, 0);
    step(2); shdn_n = 1;
    step(3);
    chk("R1 no restart without edge", en3, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule